// File: doc/BRIEF.md
# Register Slave with Masked Level Interrupt

This block is a memory-mapped register slave on one clock. A bus master issues single 32-bit reads and writes against a 6-bit byte address. The low two address bits are dropped, which leaves sixteen word slots. Read data comes back one clock later, together with its own valid strobe. Partial-word writes and bursts do not exist.

The first four slots hold the interrupt machinery and an identification word:

| Slot | Byte offset | Contents |
|------|-------------|----------|
| 0 | 0x00 | Event flags (write 1 to clear) |
| 1 | 0x04 | Per-source mask |
| 2 | 0x08 | Master gate, bit 0 |
| 3 | 0x0C | Read-only identification constant |
| 4 to 15 | 0x10 to 0x3C | Scratch words |

Eight event sources feed a pulse vector. Each pulse sets a sticky flag. The interrupt output is a level. It is high while some flag is set, that flag's mask bit is set, and the master gate is on. It falls once either enable is removed, or once every pending flag has been cleared by writing 1.

Top module: `csr_irq_slave`

## Requirements
- R1: After a synchronous active-high reset, the following are all zero: every flag, the mask, the master gate and every scratch word. The outputs `rvalid`, `rdata` and `irq` are also low.
- R2: A read request in cycle N gives `rvalid` high and `rdata` valid in cycle N+1. When `rvalid` is low, `rdata` is zero.
- R3: The word slot is `addr[5:2]`; `addr[1:0]` has no effect on reads or writes.
- R4: Slots 4 to 15 (byte offsets 0x10 to 0x3C) each store a full 32-bit word that reads back as it was written.
- R5: Slot 1 (offset 0x04) stores the mask in bits [7:0]. Slot 2 (offset 0x08) stores the master gate in bit 0. All other bits of both slots read as zero.
- R6: Slot 3 (offset 0x0C) always reads 32'h00C5_0100, and writes to it change nothing.
- R7: A one-cycle pulse on `evt[i]` sets flag bit i of slot 0 (offset 0x00) on the next edge. The bit stays set until it is cleared. Bits [31:8] of slot 0 read as zero.
- R8: Writing slot 0 clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R9: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when (flags & mask) is non-zero and the master gate is 1. It follows the register state in the same cycle, regardless of bus activity.
- R11: `irq` falls in the cycle after a write does any of these: clears the last enabled pending flag, clears the mask bits of the pending flags, or clears the master gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Byte address of the transfer |
| rd | input | 1 | Read request |
| wr | input | 1 | Write request |
| wdata | input | 32 | Write data |
| evt | input | 8 | One-cycle event pulses, one per source |
| rdata | output | 32 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read data strobe |
| irq | output | 1 | Level interrupt request |

## Verification
A corrupted flag, mask or gate bit shows up on `irq` at the next sampling point, before any register is read. It also appears in the read data one cycle after a read of the affected slot. A wrong decode shows up as a scratch word, or a protected slot, that holds an unexpected value on its next read. The stimulus includes reads at misaligned addresses, so such an error surfaces within a few transactions. The bench checks `irq` after every transaction against a model of the flags, so a lost set, a missed clear or a wrong event-versus-clear outcome is caught in the cycle after it happens.

// File: rtl/csr_irq_pkg.sv
package csr_irq_pkg;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 32;
    localparam int N_SRC   = 8;
    localparam int SLOT_W  = ADDR_W - 2;
    localparam int N_SLOTS = 1 << SLOT_W;
    localparam int N_FIXED = 4;
    localparam int N_SCR   = N_SLOTS - N_FIXED;

    localparam logic [SLOT_W-1:0] SLOT_FLAGS = SLOT_W'(0);
    localparam logic [SLOT_W-1:0] SLOT_MASK  = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] SLOT_GATE  = SLOT_W'(2);
    localparam logic [SLOT_W-1:0] SLOT_IDENT = SLOT_W'(3);

    localparam logic [DATA_W-1:0] IDENT_WORD = 32'h00C5_0100;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [N_SRC-1:0]  src_t;

    typedef struct packed {
        logic  rd;
        logic  wr;
        slot_t slot;
        word_t wdata;
    } bus_req_t;

    typedef struct packed {
        logic flags;
        logic mask;
        logic gate;
        logic ident;
        logic scratch;
    } hit_t;

    function automatic slot_t word_slot(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:2];
    endfunction

    function automatic word_t widen_src(input src_t v);
        return {{(DATA_W-N_SRC){1'b0}}, v};
    endfunction
endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_irq_pkg::*;
(
    input  bus_req_t req,
    output hit_t     wr_hit,
    output hit_t     rd_sel
);
    hit_t sel;

    always_comb begin
        sel         = '0;
        sel.flags   = (req.slot == SLOT_FLAGS);
        sel.mask    = (req.slot == SLOT_MASK);
        sel.gate    = (req.slot == SLOT_GATE);
        sel.ident   = (req.slot == SLOT_IDENT);
        sel.scratch = (req.slot >= slot_t'(N_FIXED));
    end

    assign wr_hit = req.wr ? sel : '0;
    assign rd_sel = sel;
endmodule

// File: rtl/csr_irq_bank.sv
module csr_irq_bank
    import csr_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  src_t  evt,
    input  hit_t  wr_hit,
    input  word_t wdata,
    output src_t  flags,
    output src_t  mask,
    output logic  gate,
    output logic  irq
);
    src_t flags_q, mask_q;
    logic gate_q;
    src_t clr_bits;

    assign clr_bits = wr_hit.flags ? wdata[N_SRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            mask_q  <= '0;
            gate_q  <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~clr_bits) | evt;
            if (wr_hit.mask) mask_q <= wdata[N_SRC-1:0];
            if (wr_hit.gate) gate_q <= wdata[0];
        end
    end

    assign flags = flags_q;
    assign mask  = mask_q;
    assign gate  = gate_q;
    assign irq   = gate_q & (|(flags_q & mask_q));

    // R7
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((flags_q & $past(evt)) == $past(evt)));

    // R8
    zero_keep_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hit.flags |=> ((flags_q & $past(flags_q & ~wdata[N_SRC-1:0]))
                          == $past(flags_q & ~wdata[N_SRC-1:0])));

    // R11
    clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hit.flags && evt == '0 && (flags_q & ~wdata[N_SRC-1:0]) == '0) |=> !irq);

    // R10
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hit.gate && !wdata[0]) |=> !irq);
endmodule

// File: rtl/csr_scratch_bank.sv
module csr_scratch_bank
    import csr_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  slot_t slot,
    input  word_t wdata,
    output word_t rword
);
    word_t words [N_SCR];
    word_t pick  [N_SCR];

    for (genvar g = 0; g < N_SCR; g++) begin : g_word
        localparam slot_t MY_SLOT = slot_t'(g + N_FIXED);
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= '0;
            else if (wr_en && slot == MY_SLOT)
                words[g] <= wdata;
        end
        if (g == 0) begin : g_first
            assign pick[g] = (slot == MY_SLOT) ? words[g] : '0;
        end else begin : g_rest
            assign pick[g] = pick[g-1] | ((slot == MY_SLOT) ? words[g] : '0);
        end
    end

    assign rword = pick[N_SCR-1];
endmodule

// File: rtl/csr_irq_slave.sv
module csr_irq_slave
    import csr_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  addr,
    input  logic        rd,
    input  logic        wr,
    input  logic [31:0] wdata,
    input  logic [7:0]  evt,
    output logic [31:0] rdata,
    output logic        rvalid,
    output logic        irq
);
    bus_req_t req;
    hit_t     wr_hit, rd_sel;
    src_t     flags, mask;
    logic     gate;
    word_t    scr_word, rd_mux;
    word_t    rdata_q;
    logic     rvalid_q;

    assign req.rd    = rd;
    assign req.wr    = wr;
    assign req.slot  = word_slot(addr);
    assign req.wdata = wdata;

    csr_decode u_dec (
        .req    (req),
        .wr_hit (wr_hit),
        .rd_sel (rd_sel)
    );

    csr_irq_bank u_irq (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .wr_hit (wr_hit),
        .wdata  (req.wdata),
        .flags  (flags),
        .mask   (mask),
        .gate   (gate),
        .irq    (irq)
    );

    csr_scratch_bank u_scr (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_hit.scratch),
        .slot   (req.slot),
        .wdata  (req.wdata),
        .rword  (scr_word)
    );

    always_comb begin
        rd_mux = '0;
        if (rd_sel.flags)   rd_mux = widen_src(flags);
        if (rd_sel.mask)    rd_mux = widen_src(mask);
        if (rd_sel.gate)    rd_mux = word_t'(gate);
        if (rd_sel.ident)   rd_mux = IDENT_WORD;
        if (rd_sel.scratch) rd_mux = scr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= req.rd;
            rdata_q  <= req.rd ? rd_mux : '0;
        end
    end

    assign rdata  = rdata_q;
    assign rvalid = rvalid_q;

    // R2
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        rd |=> rvalid);

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (!rvalid && rdata == '0));

    // R6
    ident_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && addr[5:2] == 4'd3) |=> (rdata == 32'h00C5_0100));
endmodule

// File: tb/csr_irq_slave_test.sv
`timescale 1ns/1ps
module csr_irq_slave_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [7:0]  evt = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    logic [7:0]  m_flags = '0;
    logic [7:0]  m_mask  = '0;
    logic        m_gate  = 1'b0;
    logic [31:0] m_scr [16];

    always #10 clk = ~clk;

    csr_irq_slave uut (
        .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .evt(evt), .rdata(rdata), .rvalid(rvalid), .irq(irq)
    );

    function automatic logic [31:0] exp_read(input int s);
        case (s)
            0: return {24'h0, m_flags};
            1: return {24'h0, m_mask};
            2: return {31'h0, m_gate};
            3: return 32'h00C5_0100;
            default: return m_scr[s];
        endcase
    endfunction

    function automatic logic exp_irq();
        return m_gate && ((m_flags & m_mask) != 8'h0);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_write(input int s, input logic [31:0] d, input logic [7:0] e);
        case (s)
            0: m_flags = (m_flags & ~d[7:0]) | e;
            1: begin m_mask = d[7:0]; m_flags = m_flags | e; end
            2: begin m_gate = d[0];   m_flags = m_flags | e; end
            3: m_flags = m_flags | e;
            default: begin m_scr[s] = d; m_flags = m_flags | e; end
        endcase
    endtask

    // one write, with an optional event pulse in the same cycle
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d, input logic [7:0] e);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; evt = e;
        @(negedge clk);
        wr = 1'b0; evt = '0;
        model_write(int'(a[5:2]), d, e);
        check("R10 irq after write", {31'h0, irq}, {31'h0, exp_irq()});
    endtask

    task automatic bus_read(input logic [5:0] a, input string tag);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check({tag, " rvalid"}, {31'h0, rvalid}, 32'h1);
        check(tag, rdata, exp_read(int'(a[5:2])));
        @(negedge clk);
        check("R2 rvalid drop", {31'h0, rvalid}, 32'h0);
        check("R2 rdata idle zero", rdata, 32'h0);
    endtask

    task automatic pulse(input logic [7:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
        m_flags = m_flags | e;
        check("R7 R10 irq after event", {31'h0, irq}, {31'h0, exp_irq()});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int unused;
        unused = $urandom(32'd1234);
        for (int i = 0; i < 16; i++) m_scr[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rvalid", {31'h0, rvalid}, 32'h0);
        check("R1 rdata", rdata, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        for (int s = 0; s < 16; s++) bus_read(6'(s * 4), "R1 reset read");

        // R6 identity slot ignores writes
        bus_write(6'h0C, 32'hFFFF_FFFF, 8'h0);
        bus_read(6'h0C, "R6 ident after write");
        // R5 upper bits read zero
        bus_write(6'h04, 32'hABCD_EF5A, 8'h0);
        bus_read(6'h04, "R5 mask");
        bus_write(6'h08, 32'hFFFF_FFFF, 8'h0);
        bus_read(6'h08, "R5 gate");
        // R4 scratch, R3 misaligned
        bus_write(6'h13, 32'hDEAD_BEEF, 8'h0);
        bus_read(6'h10, "R4 R3 scratch aligned");
        bus_read(6'h12, "R3 misaligned read");
        bus_write(6'h3C, 32'h1234_5678, 8'h0);
        bus_read(6'h3F, "R4 top scratch");

        // R7 event sets flag, irq gated by mask bit 1 (0x5A has bit 1 set)
        pulse(8'h02);
        check("R10 irq enabled source", {31'h0, irq}, 32'h1);
        bus_read(6'h00, "R7 flags");
        // R8 writing 0 keeps flag
        bus_write(6'h00, 32'h0000_0000, 8'h0);
        check("R8 zero write keeps irq", {31'h0, irq}, 32'h1);
        // R11 gate off drops irq, back on raises
        bus_write(6'h08, 32'h0, 8'h0);
        check("R11 gate off", {31'h0, irq}, 32'h0);
        bus_write(6'h08, 32'h1, 8'h0);
        check("R10 gate on", {31'h0, irq}, 32'h1);
        // R11 mask removal
        bus_write(6'h04, 32'h0, 8'h0);
        check("R11 mask off", {31'h0, irq}, 32'h0);
        bus_write(6'h04, 32'hFF, 8'h0);
        // R9 event wins over simultaneous clear
        bus_write(6'h00, 32'h0000_0002, 8'h02);
        check("R9 event wins irq", {31'h0, irq}, 32'h1);
        bus_read(6'h00, "R9 flag kept");
        // R11 clear all pending flags
        pulse(8'h81);
        bus_write(6'h00, 32'h0000_0083, 8'h0);
        check("R11 clear all", {31'h0, irq}, 32'h0);
        bus_read(6'h00, "R8 flags cleared");

        // random phase
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [5:0] a;
            logic [31:0] d;
            logic [7:0] e;
            op = int'($urandom_range(0, 3));
            a  = 6'($urandom());
            d  = $urandom();
            e  = ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 8'h0;
            if (op == 0) begin
                if ($urandom_range(0, 1) == 1) a = {4'($urandom_range(0, 2)), a[1:0]};
                bus_write(a, d, e);
            end else if (op == 1) begin
                bus_read(a, "R3 R4 R5 R7 random read");
            end else if (op == 2) begin
                pulse(e | 8'(1 << $urandom_range(0, 7)));
            end else begin
                bus_write({4'd0, a[1:0]}, d, e);
            end
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule